// File: doc/BRIEF.md
# Serial Pattern-Unlock Register Access Controller

This controller watches an asynchronous memory-style bus with active-low chip enable, output enable and write enable strobes and a single data line (data bit 0). The strobes are sampled in a synchronous clock domain. Each falling edge of chip enable counts as one bus cycle. A cycle with write enable low is a write cycle; any other cycle is a read cycle.

Ordinary memory traffic passes untouched until a 64-bit unlock key has arrived one bit per write cycle. Once the key has matched, the next 64 bus cycles carry a bit-serial exchange with eight 8-bit timekeeping registers. Write cycles shift bits in and read cycles shift bits out. During that window a blocking output keeps the normal memory from responding.

The timekeeping counters sit outside this block. It reaches them through a 64-bit parallel capture input and a 64-bit load output with a one-cycle strobe.

Top module: `keyed_serial_regport`

## Requirements
- R1: After reset, `mem_block`, `tk_load_stb` and `rd_bit_en` are all low.
- R2: The key is 64 write cycles whose data bit 0 carries bit i of the word 64'h5CA33AC55CA33AC5, for i = 0 to 63. In byte terms that is C5, 3A, A3, 5C, C5, 3A, A3, 5C, each sent least significant bit first. `mem_block` rises only after the 64th matching key bit. After 63 matching bits it is still low.
- R3: While matching the key, a write whose data bit differs from the expected key bit freezes the compare position. All later write cycles are then ignored until a read cycle occurs, so supplying the remaining correct bits does not unlock.
- R4: A read cycle outside a transfer sends the compare position back to key bit 0 and clears a frozen mismatch.
- R5: Transfer cycle k (k = 0 to 63) handles bit k of the 64-bit register word, where bit k is bit (k mod 8) of register k/8. Register r occupies bits 8r+7 to 8r of `tk_now` and `tk_load`. A read cycle presents that bit on `rd_bit`.
- R6: Bits read during a transfer come from a copy of `tk_now` taken when the key completed. Changes to `tk_now` during the transfer do not affect them.
- R7: Written bits are collected internally. After the 64th transfer cycle, if at least one of the 64 cycles was a write, `tk_load_stb` pulses for exactly one clock with the full word on `tk_load`. No pulse occurs before that point.
- R8: `mem_block` is high from key completion through the 64th transfer cycle, and low again after it.
- R9: When `tk_now` bit 36 (bit 4 of register 4) is 0, a low level on `hw_abort_n` during a transfer ends it at once. No load strobe follows. When that bit is 1, `hw_abort_n` has no effect.
- R10: `rd_bit_en` is high only during a read cycle inside a transfer while chip enable and output enable are low. It is low for read cycles outside a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of the controller |
| bus_ce_n | input | 1 | Bus chip enable, active low, asynchronous |
| bus_oe_n | input | 1 | Bus output enable, active low, asynchronous |
| bus_we_n | input | 1 | Bus write enable, active low, asynchronous |
| bus_d0 | input | 1 | Data bit 0 from the bus |
| hw_abort_n | input | 1 | Active-low transfer abort, asynchronous |
| rd_bit | output | 1 | Serial register bit for a read cycle |
| rd_bit_en | output | 1 | Drive enable for `rd_bit` |
| mem_block | output | 1 | Blocks the normal memory during a transfer |
| tk_now | input | 64 | Current value of the eight timekeeping registers |
| tk_load | output | 64 | Word to load into the timekeeping registers |
| tk_load_stb | output | 1 | One-cycle load strobe for `tk_load` |

## Verification
The assertions check on every cycle that:
- a frozen mismatch keeps the compare position fixed;
- a read cycle outside a transfer sends the position back to zero;
- `mem_block` rises only on a matching 64th key write and falls only on the 64th transfer cycle or an abort;
- the load strobe is a single-cycle pulse that never overlaps a transfer.

Only the bench's scenarios can show that the key's bit values and their order are right, that read bits follow the register order and come from the snapshot, and that a written word arrives intact. The bench sweeps a mismatch across every one of the 64 key positions and also covers the abort control bit in both states.

// File: rtl/keyed_serial_regport.sv
module keyed_serial_regport #(
  parameter int NREG = 8,
  parameter int RBITS = 8,
  parameter logic [NREG*RBITS-1:0] KEY = 64'h5CA33AC55CA33AC5,
  parameter int RST_CTL_BIT = 36
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_ce_n,
  input  logic                  bus_oe_n,
  input  logic                  bus_we_n,
  input  logic                  bus_d0,
  input  logic                  hw_abort_n,
  output logic                  rd_bit,
  output logic                  rd_bit_en,
  output logic                  mem_block,
  input  logic [NREG*RBITS-1:0] tk_now,
  output logic [NREG*RBITS-1:0] tk_load,
  output logic                  tk_load_stb
);
  localparam int NB = NREG * RBITS;
  localparam int PW = $clog2(NB);
  localparam logic [PW-1:0] LASTP = PW'(NB - 1);

  logic [1:0] ce_sy, oe_sy, we_sy, d0_sy, ab_sy;
  logic       ce_q;
  logic       xfer, stall, wrote, commit, drive, dq;
  logic [PW-1:0] kptr, xptr;
  logic [NB-1:0] sh;

  wire ce_s  = ce_sy[1];
  wire oe_s  = oe_sy[1];
  wire we_s  = we_sy[1];
  wire d0_s  = d0_sy[1];
  wire ab_s  = ab_sy[1];

  wire ev    = ce_q & ~ce_s;
  wire wr_ev = ev & ~we_s;
  wire rd_ev = ev & we_s;
  wire abort = xfer & ~ab_s & ~tk_now[RST_CTL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_sy  <= 2'b11;
      oe_sy  <= 2'b11;
      we_sy  <= 2'b11;
      d0_sy  <= 2'b00;
      ab_sy  <= 2'b11;
      ce_q   <= 1'b1;
      xfer   <= 1'b0;
      stall  <= 1'b0;
      wrote  <= 1'b0;
      commit <= 1'b0;
      drive  <= 1'b0;
      dq     <= 1'b0;
      kptr   <= '0;
      xptr   <= '0;
      sh     <= '0;
    end else begin
      ce_sy  <= {ce_sy[0], bus_ce_n};
      oe_sy  <= {oe_sy[0], bus_oe_n};
      we_sy  <= {we_sy[0], bus_we_n};
      d0_sy  <= {d0_sy[0], bus_d0};
      ab_sy  <= {ab_sy[0], hw_abort_n};
      ce_q   <= ce_s;
      commit <= 1'b0;
      if (ce_s) drive <= 1'b0;
      if (abort) begin
        xfer  <= 1'b0;
        xptr  <= '0;
        kptr  <= '0;
        stall <= 1'b0;
        wrote <= 1'b0;
        drive <= 1'b0;
      end else if (!xfer) begin
        if (rd_ev) begin
          kptr  <= '0;
          stall <= 1'b0;
        end else if (wr_ev && !stall) begin
          if (d0_s == KEY[kptr]) begin
            if (kptr == LASTP) begin
              xfer  <= 1'b1;
              kptr  <= '0;
              xptr  <= '0;
              sh    <= tk_now;
              wrote <= 1'b0;
            end else begin
              kptr <= kptr + PW'(1);
            end
          end else begin
            stall <= 1'b1;
          end
        end
      end else if (ev) begin
        if (wr_ev) begin
          sh[xptr] <= d0_s;
        end else begin
          dq    <= sh[xptr];
          drive <= 1'b1;
        end
        if (xptr == LASTP) begin
          xfer   <= 1'b0;
          xptr   <= '0;
          wrote  <= 1'b0;
          commit <= wrote | wr_ev;
        end else begin
          xptr  <= xptr + PW'(1);
          wrote <= wrote | wr_ev;
        end
      end
    end
  end

  assign mem_block   = xfer;
  assign rd_bit      = dq;
  assign rd_bit_en   = drive & ~ce_s & ~oe_s;
  assign tk_load     = sh;
  assign tk_load_stb = commit;
endmodule

// File: rtl/keyed_serial_regport_chk.sv
module keyed_serial_regport_chk #(
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev,
  input logic          wr_ev,
  input logic          rd_ev,
  input logic          xfer,
  input logic          stall,
  input logic          abort,
  input logic [PW-1:0] kptr,
  input logic [PW-1:0] xptr,
  input logic          mem_block,
  input logic          tk_load_stb
);
  localparam logic [PW-1:0] LASTP = {PW{1'b1}};

  assert_stall_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !xfer && !rd_ev) |=> (stall && kptr == $past(kptr)));

  assert_read_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && !xfer) |=> (kptr == '0 && !stall));

  assert_unlock_on_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_block) |-> ($past(kptr) == LASTP && $past(wr_ev) && !$past(stall)));

  assert_block_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_block) |-> ($past(abort) || ($past(ev) && $past(xptr) == LASTP)));

  assert_stb_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tk_load_stb |-> !mem_block);

  assert_stb_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tk_load_stb |=> !tk_load_stb);

  assert_abort_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!mem_block && !tk_load_stb));
endmodule

bind keyed_serial_regport keyed_serial_regport_chk #(.PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ev(ev), .wr_ev(wr_ev), .rd_ev(rd_ev),
  .xfer(xfer), .stall(stall), .abort(abort), .kptr(kptr), .xptr(xptr),
  .mem_block(mem_block), .tk_load_stb(tk_load_stb)
);

// File: tb/keyed_serial_regport_tb_top.sv
`timescale 1ns/1ps
module keyed_serial_regport_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_ce_n = 1'b1, bus_oe_n = 1'b1, bus_we_n = 1'b1, bus_d0 = 1'b0;
  logic hw_abort_n = 1'b1;
  logic rd_bit, rd_bit_en, mem_block, tk_load_stb;
  logic [63:0] tk_now = '0;
  logic [63:0] tk_load;

  int checks = 0, errors = 0, stb_cnt = 0;
  logic [63:0] last_load = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  keyed_serial_regport dut_i (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_d0(bus_d0), .hw_abort_n(hw_abort_n),
    .rd_bit(rd_bit), .rd_bit_en(rd_bit_en), .mem_block(mem_block),
    .tk_now(tk_now), .tk_load(tk_load), .tk_load_stb(tk_load_stb)
  );

  always @(negedge clk) if (tk_load_stb) begin
    stb_cnt++;
    last_load = tk_load;
  end

  function automatic bit keybit(int i);
    logic [7:0] kb [4];
    kb[0] = 8'hC5; kb[1] = 8'h3A; kb[2] = 8'hA3; kb[3] = 8'h5C;
    return kb[(i / 8) % 4][i % 8];
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(bit wr, bit d, output bit q, output bit en);
    bus_we_n = !wr; bus_oe_n = wr; bus_d0 = d;
    repeat (3) @(negedge clk);
    bus_ce_n = 1'b0;
    repeat (5) @(negedge clk);
    q = rd_bit; en = rd_bit_en;
    bus_ce_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_we_n = 1'b1; bus_oe_n = 1'b1;
  endtask

  task automatic wr(bit d);
    bit q, en;
    bus(1'b1, d, q, en);
  endtask

  task automatic rd(output bit q, output bit en);
    bus(1'b0, 1'b0, q, en);
  endtask

  task automatic rdx();
    bit q, en;
    rd(q, en);
  endtask

  task automatic send_key(int from, int to);
    for (int i = from; i < to; i++) wr(keybit(i));
  endtask

  task automatic unlock();
    rdx();
    send_key(0, 64);
  endtask

  task automatic write_word(logic [63:0] w);
    int s0;
    unlock();
    s0 = stb_cnt;
    for (int k = 0; k < 63; k++) wr(w[k]);
    chk(stb_cnt == s0, "R7 no early load", 64'(stb_cnt), 64'(s0));
    chk(mem_block == 1'b1, "R8 block before last", 64'(mem_block), 64'd1);
    wr(w[63]);
    chk(stb_cnt == s0 + 1, "R7 one load pulse", 64'(stb_cnt), 64'(s0 + 1));
    chk(last_load == w, "R5 R7 loaded word", last_load, w);
    chk(mem_block == 1'b0, "R8 block cleared", 64'(mem_block), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit q, en;
    int s0;
    logic [63:0] pat, w;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_block == 0, "R1 mem_block", 64'(mem_block), 0);
    chk(tk_load_stb == 0, "R1 tk_load_stb", 64'(tk_load_stb), 0);
    chk(rd_bit_en == 0, "R1 rd_bit_en", 64'(rd_bit_en), 0);

    // R10 idle read does not drive
    rd(q, en);
    chk(en == 0, "R10 idle read no drive", 64'(en), 0);

    // R2 key: 63 bits not enough, 64th unlocks
    rdx();
    send_key(0, 63);
    chk(mem_block == 0, "R2 63 bits locked", 64'(mem_block), 0);
    send_key(63, 64);
    chk(mem_block == 1, "R2 64 bits unlock", 64'(mem_block), 1);
    for (int k = 0; k < 64; k++) rdx();
    chk(mem_block == 0, "R8 exit after reads", 64'(mem_block), 0);

    // R5 R6 read transfers with several patterns
    for (int p = 0; p < 3; p++) begin
      pat = 64'h0123456789ABCDEF * 64'(p + 3) ^ (64'hF0F0 << (p * 9));
      tk_now = pat;
      s0 = stb_cnt;
      unlock();
      for (int k = 0; k < 64; k++) begin
        if (k == 32) tk_now = ~pat;
        rd(q, en);
        chk(q == pat[k], (k < 32) ? "R5 read bit order" : "R6 snapshot bit",
            64'(q), 64'(pat[k]));
        chk(en == 1, "R10 xfer read drives", 64'(en), 1);
      end
      chk(mem_block == 0, "R8 read xfer done", 64'(mem_block), 0);
      chk(stb_cnt == s0, "R7 read-only no load", 64'(stb_cnt), 64'(s0));
    end

    // R7 write transfers
    tk_now = 64'h1111_2222_3333_4444;
    write_word(64'hDEAD_BEEF_0F1E_2D3C);
    write_word(64'h8000_0000_0000_0001);
    write_word(64'h5A5A_A5A5_FFFF_0000);

    // R3 mismatch at every key position, then correct bits ignored
    for (int k = 0; k < 64; k++) begin
      rdx();
      send_key(0, k);
      wr(!keybit(k));
      send_key(k, 64);
      chk(mem_block == 0, "R3 stalled after mismatch", 64'(mem_block), 0);
    end
    unlock();
    chk(mem_block == 1, "R3 R4 read recovers", 64'(mem_block), 1);
    for (int k = 0; k < 64; k++) rdx();

    // R4 read mid-key restarts from bit 0
    foreach (pat[i]) if (i == 1 || i == 17 || i == 40 || i == 63) begin
      rdx();
      send_key(0, i);
      rdx();
      send_key(i, 64);
      chk(mem_block == 0, "R4 read restarts key", 64'(mem_block), 0);
    end

    // R9 abort honoured when control bit 36 is 0
    tk_now = 64'h0;
    s0 = stb_cnt;
    unlock();
    for (int k = 0; k < 10; k++) wr(1'b1);
    hw_abort_n = 1'b0;
    repeat (6) @(negedge clk);
    hw_abort_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mem_block == 0, "R9 abort ends xfer", 64'(mem_block), 0);
    chk(stb_cnt == s0, "R9 abort no load", 64'(stb_cnt), 64'(s0));

    // R9 abort ignored when control bit 36 is 1
    tk_now = 64'h0000_0010_0000_0000;
    w = 64'hC3C3_0000_FFFF_1234;
    unlock();
    for (int k = 0; k < 10; k++) wr(w[k]);
    hw_abort_n = 1'b0;
    repeat (6) @(negedge clk);
    hw_abort_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mem_block == 1, "R9 abort ignored", 64'(mem_block), 1);
    for (int k = 10; k < 64; k++) wr(w[k]);
    chk(stb_cnt == s0 + 1, "R9 load after ignored abort", 64'(stb_cnt), 64'(s0 + 1));
    chk(last_load == w, "R9 word intact", last_load, w);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule